// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Protected RAM

This block is a small dual-port memory with one write port and one read port. Error protection is built in logic around the storage, not taken from the memory array itself. On every write the data word is encoded with a Hamming code. An extra whole-word parity bit is added, and the full codeword is stored. On every read the stored codeword is checked. Any one flipped bit is repaired before the data leaves the block. Any two flipped bits are reported but not repaired.

Two injection inputs corrupt the codeword that is being written. This lets the repair path and the detection path be exercised in a running system with no fault in the array. The data width is a parameter and must be below 64 bits. The number of check bits comes from it: the smallest count P for which 2^P ≥ DATA_W + P + 1, plus one whole-word parity bit.

Top module: `secded_ram`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rd_valid`, `err_corrected`, `err_double` and `rd_data` are all zero.
- R2: A read asked for with `rd_en` high at a clock edge gives `rd_valid` high after that edge for exactly one cycle. `rd_data` and both flags are aligned with it. With `rd_en` low, `rd_valid` is low after the edge.
- R3: A word written with both injection inputs low reads back unchanged, with both flags low.
- R4: A write with `inj_single` high (and `inj_double` low) flips the stored bit that holds data bit 0. Reading that address returns the original data, with `err_corrected` high and `err_double` low.
- R5: A write with `inj_double` high flips the stored bits that hold data bits 0 and 1. Reading that address returns the written data XOR 3, with `err_double` high and `err_corrected` low.
- R6: If both injection inputs are high on a write, the double injection wins and the result is as in R5.
- R7: The injection inputs have no effect when `wr_en` is low. A corruption stays only until the address is written again without injection.
- R8: A read and a write to the same address in the same cycle return the contents from before the write.
- R9: Whenever `rd_valid` is low, `rd_data`, `err_corrected` and `err_double` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| inj_single | input | 1 | Corrupt one stored bit on this write |
| inj_double | input | 1 | Corrupt two stored bits on this write |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Corrected read data |
| rd_valid | output | 1 | Read result valid |
| err_corrected | output | 1 | A single-bit error was repaired |
| err_double | output | 1 | A double-bit error was detected |

## Verification
The assertions check the timing every cycle. They check that `rd_valid` follows `rd_en` by one edge, that the outputs stay silent while no read result is presented, and that the repair flag and the detection flag never rise together. Whether a given word comes back repaired, flagged or clean depends on what was written and injected earlier at that address. So the bench's directed scenarios cover the data contents: single injection, double injection, both together, injection without a write, rewrite after corruption, and a read and write to the same address in the same cycle.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int MAX_CW = 128;

    typedef enum logic [1:0] {
        ECC_CLEAN  = 2'd0,
        ECC_SINGLE = 2'd1,
        ECC_DOUBLE = 2'd2
    } ecc_kind_e;

    typedef struct packed {
        logic corrected;
        logic double_err;
    } ecc_flags_t;

    // smallest p with 2^p >= dw + p + 1
    function automatic int chk_bits(int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // codeword position (1-based Hamming index) carrying data bit idx
    function automatic int data_pos(int idx);
        int pos;
        int cnt;
        pos = 0;
        cnt = -1;
        for (int q = 1; q < MAX_CW; q++) begin
            if ((q & (q - 1)) != 0) begin
                cnt++;
                if (cnt == idx && pos == 0) pos = q;
            end
        end
        return pos;
    endfunction

    // positions 1..n covered by check bit j
    function automatic logic [MAX_CW-1:0] cover_mask(int j, int n);
        logic [MAX_CW-1:0] m;
        m = '0;
        for (int q = 1; q < MAX_CW; q++) begin
            if (q <= n) m[q] = ((q >> j) & 1) != 0;
        end
        return m;
    endfunction

    function automatic ecc_kind_e classify(logic syn_nz, logic par_err, logic syn_in_range);
        if (!par_err && !syn_nz)      return ECC_CLEAN;
        else if (par_err && syn_in_range) return ECC_SINGLE;
        else                          return ECC_DOUBLE;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
    import secded_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int P    = chk_bits(DATA_W),
    localparam int N    = DATA_W + P,
    localparam int CW_W = N + 1
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [CW_W-1:0]   cw_out
);

    logic [N:0]   placed;
    logic [P-1:0] chk;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_place
        assign placed[data_pos(gi)] = data_in[gi];
    end

    for (genvar q = 0; q <= N; q++) begin : g_zero
        if ((q & (q - 1)) == 0) begin : g_pow
            assign placed[q] = 1'b0;
        end
    end

    for (genvar j = 0; j < P; j++) begin : g_chk
        localparam logic [MAX_CW-1:0] MASK = cover_mask(j, N);
        assign chk[j] = ^(placed & MASK[N:0]);
    end

    for (genvar q = 0; q <= N; q++) begin : g_cw
        if (q == 0) begin : g_all
            assign cw_out[0] = (^placed) ^ (^chk);
        end else if ((q & (q - 1)) == 0) begin : g_chkpos
            assign cw_out[q] = chk[$clog2(q)];
        end else begin : g_data
            assign cw_out[q] = placed[q];
        end
    end

endmodule

// File: rtl/secded_inject.sv
module secded_inject #(
    parameter int CW_W  = 39,
    parameter int POS_A = 3,
    parameter int POS_B = 5
) (
    input  logic [CW_W-1:0] cw_in,
    input  logic            inj_one,
    input  logic            inj_two,
    output logic [CW_W-1:0] cw_out
);

    logic [CW_W-1:0] flip;

    always_comb begin
        flip = '0;
        if (inj_two) begin
            flip[POS_A] = 1'b1;
            flip[POS_B] = 1'b1;
        end else if (inj_one) begin
            flip[POS_A] = 1'b1;
        end
        cw_out = cw_in ^ flip;
    end

endmodule

// File: rtl/secded_sdp_mem.sv
module secded_sdp_mem #(
    parameter int WORD_W = 39,
    parameter int ADDR_W = 5,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_valid
);

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_word;
        if (rd_en) rd_word <= store[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= rd_en;
    end

endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
    import secded_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int P    = chk_bits(DATA_W),
    localparam int N    = DATA_W + P,
    localparam int CW_W = N + 1
) (
    input  logic [CW_W-1:0]   cw_in,
    input  logic              valid,
    output logic [DATA_W-1:0] data_out,
    output ecc_flags_t        flags
);

    logic [P-1:0]    syn;
    logic            par_err;
    ecc_kind_e       kind;
    logic [CW_W-1:0] fixed;

    for (genvar j = 0; j < P; j++) begin : g_syn
        localparam logic [MAX_CW-1:0] MASK = cover_mask(j, N);
        assign syn[j] = ^(cw_in & MASK[N:0]);
    end

    assign par_err = ^cw_in;
    assign kind    = classify(|syn, par_err, int'(syn) <= N);

    always_comb begin
        fixed = cw_in;
        if (kind == ECC_SINGLE) begin
            for (int q = 1; q <= N; q++) begin
                if (q == int'(syn)) fixed[q] = ~cw_in[q];
            end
        end
    end

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_extract
        assign data_out[gi] = fixed[data_pos(gi)] & valid;
    end

    assign flags.corrected  = valid && (kind == ECC_SINGLE);
    assign flags.double_err = valid && (kind == ECC_DOUBLE);

endmodule

// File: rtl/secded_ram.sv
module secded_ram
    import secded_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inj_single,
    input  logic              inj_double,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              err_corrected,
    output logic              err_double
);

    localparam int P    = chk_bits(DATA_W);
    localparam int CW_W = DATA_W + P + 1;

    logic [CW_W-1:0] enc_word;
    logic [CW_W-1:0] store_word;
    logic [CW_W-1:0] read_word;
    ecc_flags_t      flags;

    secded_encoder #(.DATA_W(DATA_W)) u_enc (
        .data_in (wr_data),
        .cw_out  (enc_word)
    );

    secded_inject #(
        .CW_W  (CW_W),
        .POS_A (data_pos(0)),
        .POS_B (data_pos(1))
    ) u_inj (
        .cw_in   (enc_word),
        .inj_one (inj_single & wr_en),
        .inj_two (inj_double & wr_en),
        .cw_out  (store_word)
    );

    secded_sdp_mem #(.WORD_W(CW_W), .ADDR_W(ADDR_W)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_word  (store_word),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_word  (read_word),
        .rd_valid (rd_valid)
    );

    secded_decoder #(.DATA_W(DATA_W)) u_dec (
        .cw_in    (read_word),
        .valid    (rd_valid),
        .data_out (rd_data),
        .flags    (flags)
    );

    assign err_corrected = flags.corrected;
    assign err_double    = flags.double_err;

endmodule

// File: rtl/secded_ram_checks.sv
module secded_ram_checks #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              err_corrected,
    input logic              err_double
);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (!err_corrected && !err_double && rd_data == '0));

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(err_corrected && err_double));

endmodule

bind secded_ram secded_ram_checks #(.DATA_W(DATA_W)) u_checks (
    .clk           (clk),
    .rst           (rst),
    .rd_en         (rd_en),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .err_corrected (err_corrected),
    .err_double    (err_double)
);

// File: tb/secded_ram_test.sv
module secded_ram_test;

    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          inj_single = 1'b0;
    logic          inj_double = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          err_corrected;
    logic          err_double;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    secded_ram #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .inj_single (inj_single), .inj_double (inj_double),
        .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data),
        .rd_valid (rd_valid), .err_corrected (err_corrected), .err_double (err_double)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(logic [AW-1:0] a, logic [DW-1:0] d, logic s1, logic s2);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; inj_single = s1; inj_double = s2;
        @(negedge clk);
        wr_en = 1'b0; inj_single = 1'b0; inj_double = 1'b0;
    endtask

    task automatic read_word(logic [AW-1:0] a, output logic [DW-1:0] d,
                             output logic v, output logic c, output logic e);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data; v = rd_valid; c = err_corrected; e = err_double;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 valid in reset", 64'(rd_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", 64'(rd_valid), 0);
        check("R1 flags after reset", {62'd0, err_corrected, err_double}, 0);
        check("R1 data after reset", 64'(rd_data), 0);
    endtask

    task automatic t_clean();
        logic [DW-1:0] d; logic v, c, e;
        logic [DW-1:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h8000_0001};
        for (int i = 0; i < 4; i++) begin
            write_word(AW'(i + 1), pats[i], 1'b0, 1'b0);
            read_word(AW'(i + 1), d, v, c, e);
            check("R2 valid on read", 64'(v), 1);
            check("R3 clean data", 64'(d), 64'(pats[i]));
            check("R3 clean flags", {62'd0, c, e}, 0);
        end
        @(negedge clk);
        check("R2 valid drops", 64'(rd_valid), 0);
        check("R9 data quiet", 64'(rd_data), 0);
    endtask

    task automatic t_single();
        logic [DW-1:0] d; logic v, c, e;
        write_word(5'd10, 32'h1234_5678, 1'b1, 1'b0);
        read_word(5'd10, d, v, c, e);
        check("R4 corrected data", 64'(d), 64'h1234_5678);
        check("R4 flags", {62'd0, c, e}, 2'b10);
    endtask

    task automatic t_double();
        logic [DW-1:0] d; logic v, c, e;
        write_word(5'd11, 32'hCAFE_F00C, 1'b0, 1'b1);
        read_word(5'd11, d, v, c, e);
        check("R5 raw data", 64'(d), 64'(32'hCAFE_F00C ^ 32'h3));
        check("R5 flags", {62'd0, c, e}, 2'b01);
    endtask

    task automatic t_both();
        logic [DW-1:0] d; logic v, c, e;
        write_word(5'd12, 32'h0F0F_0F0F, 1'b1, 1'b1);
        read_word(5'd12, d, v, c, e);
        check("R6 data", 64'(d), 64'(32'h0F0F_0F0F ^ 32'h3));
        check("R6 flags", {62'd0, c, e}, 2'b01);
    endtask

    task automatic t_no_write_inject();
        logic [DW-1:0] d; logic v, c, e;
        write_word(5'd20, 32'h5555_AAAA, 1'b0, 1'b0);
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 5'd20; wr_data = 32'h0; inj_single = 1'b1; inj_double = 1'b1;
        @(negedge clk);
        inj_single = 1'b0; inj_double = 1'b0;
        read_word(5'd20, d, v, c, e);
        check("R7 no write data", 64'(d), 64'h5555_AAAA);
        check("R7 no write flags", {62'd0, c, e}, 0);
        write_word(5'd11, 32'h7777_0000, 1'b0, 1'b0);
        read_word(5'd11, d, v, c, e);
        check("R7 rewrite data", 64'(d), 64'h7777_0000);
        check("R7 rewrite flags", {62'd0, c, e}, 0);
    endtask

    task automatic t_same_cycle();
        logic [DW-1:0] d; logic v, c, e;
        write_word(5'd25, 32'hDEAD_BEEF, 1'b0, 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd25; wr_data = 32'h1111_2222;
        rd_en = 1'b1; rd_addr = 5'd25;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R8 old data", 64'(rd_data), 64'hDEAD_BEEF);
        check("R8 valid", 64'(rd_valid), 1);
        read_word(5'd25, d, v, c, e);
        check("R8 new data", 64'(d), 64'h1111_2222);
    endtask

    initial begin
        #(5ns * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_clean();
        t_single();
        t_double();
        t_both();
        t_no_write_inject();
        t_same_cycle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule